// File: doc/BRIEF.md
# Processor Subsystem Power-Up Sequencer

This block takes a processor subsystem from a cold, held state to running code by writing the bits of three control registers in a fixed order: a reset-control register, a power-control register and a clock-select register. A single-cycle `start_i` in idle launches the sequence. The sequencer first holds the core and its bus in reset. It then switches on the power block and waits a programmable number of cycles for the supply to settle. Next it wakes the retention and standby controls of the memories, and then turns on the cache data banks one at a time, from the highest bank down, with a programmable gap between them to limit inrush current. Finally it releases the IO clamp, takes the core out of reset, enables the core clock and lets the core run.

The register outputs are the control bits themselves, so a neighbour that decodes them sees each write in the cycle it happens. Only one register changes per write. `busy_o` is high while the sequence is in progress and `done_o` is high once the core is released. A `pdown_i` request returns all three registers to their reset values in one cycle from any state and leaves the block idle.

Top module: `pwrup_seq`

## Requirements
- R1: After reset the reset-control register is 0, the power-control register holds only the IO clamp (bit 20, value 0x100000), the clock-select register is 0, and `busy_o` and `done_o` are low.
- R2: When `start_i` is seen in idle, `busy_o` rises after that edge. One edge later, stop-core (bit 0), core reset (bit 1) and bus reset (bit 2) of the reset-control register are all set in the same write.
- R3: On the next edge, power-block-on (bit 21) and regulator bypass (bit 22) are set together. No register then changes for SETTLE_CYC edges.
- R4: On the edge after the settle wait, bits 16, 17, 18 and 19 of the power-control register are set in one write.
- R5: The data-bank bits NUM_BANKS-1 down to 0 of the power-control register are then set one per write, highest first. The first bank is written on the edge after R4, and BANK_GAP quiet cycles separate consecutive bank writes.
- R6: On the edge after the last bank, the IO clamp (bit 20) is cleared. On each of the next three edges, in this order: core reset (bit 1) is cleared, clock enable (clock-select bit 1) is set, and stop-core (bit 0) is cleared.
- R7: `done_o` rises and `busy_o` falls on the edge that clears stop-core. The registers then hold their values until power-down.
- R8: `start_i` has no effect while the sequence runs or after it has completed.
- R9: `pdown_i` returns all three registers to their R1 values and the block to idle on the next edge, from any state. It takes precedence over a simultaneous `start_i`.
- R10: Apart from a power-down, at most one of the three registers changes on any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin power-up from idle |
| pdown_i | input | 1 | Return to reset values and idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Core released and running |
| rst_ctl_o | output | 3 | Reset-control register |
| pwr_ctl_o | output | 23 | Power-control register |
| clk_ctl_o | output | 2 | Clock-select register |

## Verification
The bench builds the block with SETTLE_CYC=6, BANK_GAP=2 and NUM_BANKS=3. With these values the settle window and each bank gap span several cycles, which is enough to observe that the registers stay still inside each wait. Three banks give two separate inter-bank gaps, so power-down can be requested inside a gap, on a bank write, and at each release step. The bench also keeps `start_i` high across several edges of a running sequence to show that the extra cycles are ignored.

// File: rtl/psu_pkg.sv
package psu_pkg;

   // register widths
   localparam int RST_W = 3;
   localparam int PWR_W = 23;
   localparam int CLK_W = 2;

   // reset-control bit positions
   localparam int RB_STOP = 0;
   localparam int RB_CORE = 1;
   localparam int RB_BUS  = 2;

   // power-control bit positions (banks occupy [NUM_BANKS-1:0])
   localparam int PB_TAG   = 16;
   localparam int PB_TRACE = 17;
   localparam int PB_STBY  = 18;
   localparam int PB_SLEEP = 19;
   localparam int PB_CLAMP = 20;
   localparam int PB_HS    = 21;
   localparam int PB_BYP   = 22;
   localparam int MAX_BANKS = PB_TAG;

   // clock-select bit position
   localparam int CB_EN = 1;

   localparam logic [PWR_W-1:0] PWR_RST_VAL = PWR_W'(1) << PB_CLAMP;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RST, ST_HS, ST_SETTLE, ST_MEM, ST_BANK, ST_GAP,
      ST_UNCLAMP, ST_REL, ST_CLK, ST_GO, ST_DONE
   } seq_st_e;

   typedef enum logic [3:0] {
      OP_NONE, OP_RST_ALL, OP_HS, OP_MEM, OP_BANK,
      OP_UNCLAMP, OP_REL, OP_CLK, OP_GO
   } wr_op_e;

endpackage

// File: rtl/psu_wait_cnt.sv
module psu_wait_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         dec_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   if (W < 1) begin : g_bad_w
      $error("psu_wait_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr_i)          cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // a decrement request is only made while counting
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && !clr_i) |-> (cnt_q != '0));
endmodule

// File: rtl/psu_bank_ptr.sv
module psu_bank_ptr #(
   parameter int NB = 3,
   localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          load_i,
   input  logic          dec_i,
   output logic [IW-1:0] idx_o,
   output logic          last_o
);
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (clr_i)   idx_q <= '0;
      else if (load_i)  idx_q <= IW'(NB - 1);
      else if (dec_i)   idx_q <= idx_q - 1'b1;
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == '0);

   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) < NB);
   p_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i && !clr_i) |=> (32'(idx_q) + 1 == 32'($past(idx_q))));
endmodule

// File: rtl/psu_ctl_regs.sv
module psu_ctl_regs
   import psu_pkg::*;
#(
   parameter int NB = 3,
   localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  wr_op_e           op_i,
   input  logic [IW-1:0]    bank_i,
   output logic [RST_W-1:0] rst_q,
   output logic [PWR_W-1:0] pwr_q,
   output logic [CLK_W-1:0] clk_q
);
   localparam logic [RST_W-1:0] RST_ALL =
      (RST_W'(1) << RB_STOP) | (RST_W'(1) << RB_CORE) | (RST_W'(1) << RB_BUS);
   localparam logic [PWR_W-1:0] HS_BITS =
      (PWR_W'(1) << PB_HS) | (PWR_W'(1) << PB_BYP);
   localparam logic [PWR_W-1:0] MEM_BITS =
      (PWR_W'(1) << PB_TAG) | (PWR_W'(1) << PB_TRACE) |
      (PWR_W'(1) << PB_STBY) | (PWR_W'(1) << PB_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr_i) begin
         rst_q <= '0;
         pwr_q <= PWR_RST_VAL;
         clk_q <= '0;
      end else begin
         unique case (op_i)
            OP_RST_ALL: rst_q <= rst_q | RST_ALL;
            OP_HS:      pwr_q <= pwr_q | HS_BITS;
            OP_MEM:     pwr_q <= pwr_q | MEM_BITS;
            OP_BANK:    pwr_q[bank_i] <= 1'b1;
            OP_UNCLAMP: pwr_q[PB_CLAMP] <= 1'b0;
            OP_REL:     rst_q[RB_CORE] <= 1'b0;
            OP_CLK:     clk_q[CB_EN] <= 1'b1;
            OP_GO:      rst_q[RB_STOP] <= 1'b0;
            default: ;
         endcase
      end
   end

   // one register per write
   p_one_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_i) |-> ($countones({rst_q != $past(rst_q), pwr_q != $past(pwr_q),
                                     clk_q != $past(clk_q)}) <= 1));

   // banks come up highest first
   for (genvar b = 0; b < NB - 1; b++) begin : g_bank_chk
      p_bank_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwr_q[b]) |-> pwr_q[b+1]);
   end

   p_unclamp_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_q[PB_CLAMP]) |-> (&pwr_q[NB-1:0]));
   p_clk_after_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_q[CB_EN]) |-> !rst_q[RB_CORE] && !pwr_q[PB_CLAMP]);
   p_stop_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_q[RB_STOP]) && !$past(clr_i)) |-> clk_q[CB_EN]);
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
   import psu_pkg::*;
#(
   parameter int SETTLE_CYC = 16,
   parameter int BANK_GAP   = 2,
   parameter int NUM_BANKS  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      pdown_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [psu_pkg::RST_W-1:0] rst_ctl_o,
   output logic [psu_pkg::PWR_W-1:0] pwr_ctl_o,
   output logic [psu_pkg::CLK_W-1:0] clk_ctl_o
);
   localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam int GW = (BANK_GAP > 1) ? $clog2(BANK_GAP) : 1;
   localparam int IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam bit GAP_EN = (BANK_GAP > 0);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("pwrup_seq: SETTLE_CYC must be at least 1");
   end
   if (BANK_GAP < 0) begin : g_bad_gap
      $error("pwrup_seq: BANK_GAP must not be negative");
   end
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("pwrup_seq: NUM_BANKS out of range");
   end

   seq_st_e st_q, st_d;
   wr_op_e  op;
   logic set_ld, set_dec, set_zero;
   logic gap_ld, gap_dec, gap_zero;
   logic bk_ld, bk_dec, bk_last;
   logic [IW-1:0] bk_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d    = st_q;
      op      = OP_NONE;
      set_ld  = 1'b0;
      set_dec = 1'b0;
      gap_ld  = 1'b0;
      gap_dec = 1'b0;
      bk_ld   = 1'b0;
      bk_dec  = 1'b0;
      if (pdown_i) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_RST;
            ST_RST:     begin op = OP_RST_ALL; st_d = ST_HS; end
            ST_HS:      begin op = OP_HS; set_ld = 1'b1; st_d = ST_SETTLE; end
            ST_SETTLE:  if (set_zero) st_d = ST_MEM; else set_dec = 1'b1;
            ST_MEM:     begin op = OP_MEM; bk_ld = 1'b1; st_d = ST_BANK; end
            ST_BANK: begin
               op = OP_BANK;
               if (bk_last) st_d = ST_UNCLAMP;
               else begin
                  bk_dec = 1'b1;
                  if (GAP_EN) begin
                     gap_ld = 1'b1;
                     st_d   = ST_GAP;
                  end
               end
            end
            ST_GAP:     if (gap_zero) st_d = ST_BANK; else gap_dec = 1'b1;
            ST_UNCLAMP: begin op = OP_UNCLAMP; st_d = ST_REL; end
            ST_REL:     begin op = OP_REL; st_d = ST_CLK; end
            ST_CLK:     begin op = OP_CLK; st_d = ST_GO; end
            ST_GO:      begin op = OP_GO; st_d = ST_DONE; end
            ST_DONE:    st_d = ST_DONE;
            default:    st_d = ST_IDLE;
         endcase
      end
   end

   psu_wait_cnt #(.W(SW)) i_settle (
      .clk(clk), .rst_n(rst_n), .clr_i(pdown_i), .load_i(set_ld),
      .val_i(SW'(SETTLE_CYC - 1)), .dec_i(set_dec), .zero_o(set_zero)
   );

   if (GAP_EN) begin : g_gap
      psu_wait_cnt #(.W(GW)) i_gap (
         .clk(clk), .rst_n(rst_n), .clr_i(pdown_i), .load_i(gap_ld),
         .val_i(GW'(BANK_GAP - 1)), .dec_i(gap_dec), .zero_o(gap_zero)
      );
   end else begin : g_nogap
      logic unused_gap;
      assign unused_gap = gap_ld ^ gap_dec;
      assign gap_zero   = 1'b1;
   end

   psu_bank_ptr #(.NB(NUM_BANKS)) i_bank (
      .clk(clk), .rst_n(rst_n), .clr_i(pdown_i), .load_i(bk_ld),
      .dec_i(bk_dec), .idx_o(bk_idx), .last_o(bk_last)
   );

   psu_ctl_regs #(.NB(NUM_BANKS)) i_regs (
      .clk(clk), .rst_n(rst_n), .clr_i(pdown_i), .op_i(op), .bank_i(bk_idx),
      .rst_q(rst_ctl_o), .pwr_q(pwr_ctl_o), .clk_q(clk_ctl_o)
   );

   assign busy_o = (st_q != ST_IDLE) && (st_q != ST_DONE);
   assign done_o = (st_q == ST_DONE);

   p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RST && !pdown_i) |=> (&rst_ctl_o));
   p_settle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SETTLE && !pdown_i) |=>
         ($stable(rst_ctl_o) && $stable(pwr_ctl_o) && $stable(clk_ctl_o)));
   p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !pdown_i) |=> (done_o && $stable(rst_ctl_o) &&
                                $stable(pwr_ctl_o) && $stable(clk_ctl_o)));
   p_pdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pdown_i |=> (rst_ctl_o == '0 && pwr_ctl_o == PWR_RST_VAL &&
                   clk_ctl_o == '0 && !busy_o && !done_o));
endmodule

// File: tb/test_pwrup_seq.sv
`timescale 1ns/1ps
module test_pwrup_seq;
   localparam int S  = 6;
   localparam int G  = 2;
   localparam int NB = 3;
   localparam int TM = 3 + S;
   localparam int TU = TM + 1 + (NB - 1) * (G + 1) + 1;
   localparam int TG = TU + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic pdown_i = 1'b0;
   logic busy_o, done_o;
   logic [2:0]  rst_ctl_o;
   logic [22:0] pwr_ctl_o;
   logic [1:0]  clk_ctl_o;

   int errs = 0;
   int chks = 0;
   int cyc  = 0;

   always #4 clk = ~clk;

   pwrup_seq #(.SETTLE_CYC(S), .BANK_GAP(G), .NUM_BANKS(NB)) i_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pdown_i(pdown_i),
      .busy_o(busy_o), .done_o(done_o), .rst_ctl_o(rst_ctl_o),
      .pwr_ctl_o(pwr_ctl_o), .clk_ctl_o(clk_ctl_o)
   );

   wire [29:0] snap = {busy_o, done_o, clk_ctl_o, rst_ctl_o, pwr_ctl_o};

   // expected {busy,done,clk,rst,pwr} t edges after start was seen (t<0: idle)
   function automatic logic [29:0] exp_at(int t);
      logic [22:0] p = 23'h100000;
      logic [2:0]  r = 3'b000;
      logic [1:0]  c = 2'b00;
      logic b = 1'b0, d = 1'b0;
      if (t >= 0) b = 1'b1;
      if (t >= 1) r = 3'b111;
      if (t >= 2) p = p | 23'h600000;
      if (t >= TM) p = p | 23'h0F0000;
      for (int k = 0; k < NB; k++)
         if (t >= TM + 1 + k * (G + 1)) p[NB-1-k] = 1'b1;
      if (t >= TU) p[20] = 1'b0;
      if (t >= TU + 1) r[1] = 1'b0;
      if (t >= TU + 2) c[1] = 1'b1;
      if (t >= TG) begin r[0] = 1'b0; b = 1'b0; d = 1'b1; end
      return {b, d, c, r, p};
   endfunction

   function automatic string tag_at(int t);
      if (t <= 1)  return "R2";
      if (t < TM)  return "R3";
      if (t == TM) return "R4";
      if (t < TU)  return "R5";
      if (t < TG)  return "R6";
      return "R7";
   endfunction

   task automatic check(string tag, logic [29:0] act, logic [29:0] exp);
      chks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // launch with start held slen edges, follow to step 'stop_at'
   task automatic launch(int slen, int stop_at);
      @(negedge clk);
      start_i = 1'b1;
      for (int t = 0; t <= stop_at; t++) begin
         @(negedge clk);
         check(tag_at(t), snap, exp_at(t));
         if (t + 1 >= slen) start_i = 1'b0;   // extra start edges: R8
      end
   endtask

   task automatic power_down(bit with_start);
      pdown_i = 1'b1;
      start_i = with_start;
      @(negedge clk);
      check("R9", snap, exp_at(-1));
      pdown_i = 1'b0;
      start_i = 1'b0;
      @(negedge clk);
      check("R9", snap, exp_at(-1));   // start beside pdown had no effect
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errs++;
         chks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1", snap, exp_at(-1));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", snap, exp_at(-1));

      // pdown while idle changes nothing (R9)
      @(negedge clk);
      power_down(1'b0);

      // directed full sequence, one-cycle start
      launch(1, TG + 3);
      // start while done is ignored (R8)
      start_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R8", snap, exp_at(TG));
      end
      start_i = 1'b0;
      power_down(1'b1);

      // directed aborts at corners: first write, mem write, each bank, release steps
      launch(1, 0);              power_down(1'b1);
      launch(1, TM);             power_down(1'b0);
      for (int k = 0; k < NB; k++) begin
         launch(1, TM + 1 + k * (G + 1));
         power_down(1'b1);
      end
      launch(1, TM + 2);         power_down(1'b0);   // inside a gap
      launch(1, TU);             power_down(1'b0);
      launch(1, TG - 1);         power_down(1'b1);

      // random runs: start length and abort point
      for (int n = 0; n < 24; n++) begin
         int slen = 1 + int'($urandom % 5);
         int stop = int'($urandom % (TG + 4));
         launch(slen, stop);
         if (stop >= TG) begin
            start_i = 1'b1;
            @(negedge clk);
            check("R8", snap, exp_at(TG));
            start_i = 1'b0;
         end
         power_down(1'($urandom % 2));
      end

      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end
endmodule